// File: doc/BRIEF.md
# Cluster Core Power State Controller

This block keeps each core of a cluster either running or power-gated, and holds one operating-frequency level that every core of the cluster shares. A scheduling agent outside the block sends single-cycle sleep and wake pulses per core, on and off pulses for each core's floating-point coprocessor supply, and frequency-level requests. The block drives the power-gate enables, a per-core ready flag, the coprocessor supply enables and the current frequency level.

A core moves from running to gated on a sleep pulse. A wake pulse starts a recovery interval whose length comes from a static configuration value. The core is flagged ready only when that interval has ended. Frequency levels are numbered upward from slowest to fastest. A level change is only taken while no core is recovering, so a core never finishes its wake-up at a clock it did not start with. The coprocessor supply of each core is switched apart from the core's own state.

Top module: `core_pwr_ctrl`

## Requirements
- R1: After reset every core is running (ready high, gate enable low), every coprocessor supply is off and the frequency level is RESET_LEVEL (default 0).
- R2: A sleep pulse to a running core sets its gate enable and clears its ready flag on the next clock edge. If a wake pulse arrives in the same cycle, the sleep pulse wins.
- R3: A wake pulse to a gated core clears its gate enable on the next edge. Ready rises exactly L+1 edges after the wake edge, where L is the wake latency, so L = 0 gives a one-cycle wake.
- R4: Ready is high only while a core is running. It stays low throughout recovery.
- R5: A sleep pulse seen during recovery is held. When the recovery count ends, the core returns straight to gated, and ready never rises.
- R6: A wake pulse to a running core and a sleep pulse to a gated core have no effect.
- R7: The wake latency is captured when the wake pulse is taken. Changing the configuration input during recovery does not alter that recovery's length.
- R8: With no core recovering, a valid frequency request appears on the level output on the next edge.
- R9: While any core is recovering, a frequency request is held pending and the level output stays unchanged. A newer request replaces the pending one. The pending level is applied on the edge after the last recovering core leaves recovery.
- R10: A request with a level index of NUM_LEVELS or more is ignored. It leaves both the current level and any pending level unchanged.
- R11: Each coprocessor supply enable is set by its on pulse and cleared by its off pulse on the next edge. Off wins when both arrive together. Core sleep and wake do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_lat_i | input | WAKE_W | Static wake latency L, in cycles beyond the first |
| sleep_req_i | input | NUM_CORES | Per-core sleep pulse |
| wake_req_i | input | NUM_CORES | Per-core wake pulse |
| freq_req_vld_i | input | 1 | Frequency request strobe |
| freq_req_idx_i | input | FREQ_W | Requested level, 0 slowest |
| cop_on_req_i | input | NUM_CORES | Per-core coprocessor on pulse |
| cop_off_req_i | input | NUM_CORES | Per-core coprocessor off pulse |
| pgate_en_o | output | NUM_CORES | Power gate enable, 1 = gated |
| core_ready_o | output | NUM_CORES | Core running and usable |
| cop_pwr_en_o | output | NUM_CORES | Coprocessor supply enable |
| freq_idx_o | output | FREQ_W | Current cluster frequency level |

## Verification
A core stuck in recovery or losing its count shows up as ready rising one edge early or late. That error appears within L+2 cycles of the wake pulse, so the bench samples ready on the edge just before the expected rise and again on the edge of the rise itself. A lost held sleep shows up as ready rising instead of the gate enable returning high. A wrong recovery status for the frequency hold shows up as the level output moving while a core is still recovering, or staying stale one edge after recovery ends. Out-of-range and overwritten requests are caught by checking which level finally appears once recovery is over.

// File: rtl/cps_pkg.sv
package cps_pkg;
   typedef enum logic [1:0] {
      CPS_RUN  = 2'd0,
      CPS_GATE = 2'd1,
      CPS_WAKE = 2'd2
   } cps_state_e;
endpackage

// File: rtl/cps_core_fsm.sv
module cps_core_fsm
   import cps_pkg::*;
#(
   parameter int WAKE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sleep_req_i,
   input  logic              wake_req_i,
   input  logic [WAKE_W-1:0] wake_lat_i,
   output logic              gate_en_o,
   output logic              ready_o,
   output logic              waking_o
);
   cps_state_e        state_q;
   logic [WAKE_W-1:0] cnt_q;
   logic              held_q;
   logic              cnt_done;

   assign cnt_done = (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= CPS_RUN;
         cnt_q   <= '0;
         held_q  <= 1'b0;
      end else begin
         case (state_q)
            CPS_RUN: begin
               if (sleep_req_i) state_q <= CPS_GATE;
            end
            CPS_GATE: begin
               if (wake_req_i) begin
                  state_q <= CPS_WAKE;
                  cnt_q   <= wake_lat_i;
                  held_q  <= 1'b0;
               end
            end
            CPS_WAKE: begin
               if (sleep_req_i) held_q <= 1'b1;
               if (cnt_done) begin
                  state_q <= (held_q || sleep_req_i) ? CPS_GATE : CPS_RUN;
                  held_q  <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= CPS_RUN;
         endcase
      end
   end

   assign gate_en_o = (state_q == CPS_GATE);
   assign ready_o   = (state_q == CPS_RUN);
   assign waking_o  = (state_q == CPS_WAKE);

   AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && sleep_req_i) |=> (gate_en_o && !ready_o)); // R2
   AST_WAKE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_en_o && wake_req_i) |=> (waking_o && cnt_q == $past(wake_lat_i))); // R7
   AST_WAKE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waking_o && !cnt_done) |=> (waking_o && cnt_q == $past(cnt_q) - 1'b1)); // R3
   AST_HELD_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waking_o && cnt_done && held_q) |=> (gate_en_o && !ready_o)); // R5
   AST_GATE_IGNORES_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_en_o && !wake_req_i) |=> gate_en_o); // R6
endmodule

// File: rtl/cps_freq_sel.sv
module cps_freq_sel #(
   parameter int FREQ_W      = 3,
   parameter int NUM_LEVELS  = 6,
   parameter int RESET_LEVEL = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hold_i,
   input  logic              req_vld_i,
   input  logic [FREQ_W-1:0] req_idx_i,
   output logic [FREQ_W-1:0] cur_idx_o
);
   logic [FREQ_W-1:0] cur_q;
   logic [FREQ_W-1:0] pend_idx_q;
   logic              pend_q;
   logic              req_ok;
   logic [FREQ_W-1:0] next_idx;

   assign req_ok   = req_vld_i && (int'(req_idx_i) < NUM_LEVELS);
   assign next_idx = req_ok ? req_idx_i : pend_idx_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q      <= FREQ_W'(RESET_LEVEL);
         pend_idx_q <= FREQ_W'(RESET_LEVEL);
         pend_q     <= 1'b0;
      end else if ((req_ok || pend_q) && !hold_i) begin
         cur_q  <= next_idx;
         pend_q <= 1'b0;
      end else if (req_ok) begin
         pend_idx_q <= req_idx_i;
         pend_q     <= 1'b1;
      end
   end

   assign cur_idx_o = cur_q;

   AST_FREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> $stable(cur_idx_o)); // R9
   AST_FREQ_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(cur_idx_o) < NUM_LEVELS); // R10
endmodule

// File: rtl/cps_cop_gate.sv
module cps_cop_gate #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_CORES-1:0] on_req_i,
   input  logic [NUM_CORES-1:0] off_req_i,
   output logic [NUM_CORES-1:0] en_o
);
   for (genvar g = 0; g < NUM_CORES; g++) begin : g_cop
      logic en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)           en_q <= 1'b0;
         else if (off_req_i[g]) en_q <= 1'b0;
         else if (on_req_i[g])  en_q <= 1'b1;
      end
      assign en_o[g] = en_q;

      AST_COP_OFF_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         off_req_i[g] |=> !en_o[g]); // R11
      AST_COP_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (on_req_i[g] && !off_req_i[g]) |=> en_o[g]); // R11
   end
endmodule

// File: rtl/core_pwr_ctrl.sv
module core_pwr_ctrl #(
   parameter int NUM_CORES   = 4,
   parameter int NUM_LEVELS  = 6,
   parameter int WAKE_W      = 6,
   parameter int RESET_LEVEL = 0,
   localparam int FREQ_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [WAKE_W-1:0]    wake_lat_i,
   input  logic [NUM_CORES-1:0] sleep_req_i,
   input  logic [NUM_CORES-1:0] wake_req_i,
   input  logic                 freq_req_vld_i,
   input  logic [FREQ_W-1:0]    freq_req_idx_i,
   input  logic [NUM_CORES-1:0] cop_on_req_i,
   input  logic [NUM_CORES-1:0] cop_off_req_i,
   output logic [NUM_CORES-1:0] pgate_en_o,
   output logic [NUM_CORES-1:0] core_ready_o,
   output logic [NUM_CORES-1:0] cop_pwr_en_o,
   output logic [FREQ_W-1:0]    freq_idx_o
);
   if (NUM_CORES < 1)                   begin : g_chk_cores $error("NUM_CORES must be at least 1"); end
   if (NUM_LEVELS < 2)                  begin : g_chk_lvls  $error("NUM_LEVELS must be at least 2"); end
   if (WAKE_W < 1)                      begin : g_chk_wake  $error("WAKE_W must be at least 1"); end
   if (RESET_LEVEL < 0 || RESET_LEVEL >= NUM_LEVELS)
                                        begin : g_chk_rst   $error("RESET_LEVEL out of range"); end

   logic [NUM_CORES-1:0] waking;
   logic                 any_waking;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      cps_core_fsm #(.WAKE_W(WAKE_W)) u_fsm (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .sleep_req_i (sleep_req_i[c]),
         .wake_req_i  (wake_req_i[c]),
         .wake_lat_i  (wake_lat_i),
         .gate_en_o   (pgate_en_o[c]),
         .ready_o     (core_ready_o[c]),
         .waking_o    (waking[c])
      );
   end

   assign any_waking = |waking;

   cps_freq_sel #(
      .FREQ_W      (FREQ_W),
      .NUM_LEVELS  (NUM_LEVELS),
      .RESET_LEVEL (RESET_LEVEL)
   ) u_freq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hold_i    (any_waking),
      .req_vld_i (freq_req_vld_i),
      .req_idx_i (freq_req_idx_i),
      .cur_idx_o (freq_idx_o)
   );

   cps_cop_gate #(.NUM_CORES(NUM_CORES)) u_cop (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .on_req_i  (cop_on_req_i),
      .off_req_i (cop_off_req_i),
      .en_o      (cop_pwr_en_o)
   );

   AST_READY_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_ready_o & (pgate_en_o | waking)) == '0); // R4
endmodule

// File: tb/core_pwr_ctrl_tb.sv
module core_pwr_ctrl_tb_top;
   localparam int NC = 4;
   localparam int NL = 6;
   localparam int WW = 6;
   localparam int FW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [WW-1:0] wake_lat = '0;
   logic [NC-1:0] sleep_req = '0, wake_req = '0, cop_on = '0, cop_off = '0;
   logic          fvld = 1'b0;
   logic [FW-1:0] fidx = '0;
   logic [NC-1:0] pgate, ready, cop_en;
   logic [FW-1:0] freq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   core_pwr_ctrl #(.NUM_CORES(NC), .NUM_LEVELS(NL), .WAKE_W(WW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wake_lat_i(wake_lat),
      .sleep_req_i(sleep_req), .wake_req_i(wake_req),
      .freq_req_vld_i(fvld), .freq_req_idx_i(fidx),
      .cop_on_req_i(cop_on), .cop_off_req_i(cop_off),
      .pgate_en_o(pgate), .core_ready_o(ready),
      .cop_pwr_en_o(cop_en), .freq_idx_o(freq));

   localparam logic [FW-1:0] VEC_REQ [0:7] = '{3'd3, 3'd5, 3'd7, 3'd0, 3'd6, 3'd2, 3'd1, 3'd4};
   localparam logic [FW-1:0] VEC_EXP [0:7] = '{3'd3, 3'd5, 3'd5, 3'd0, 3'd0, 3'd2, 3'd1, 3'd4};

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // drive pulses at negedge, hold across one posedge, release at the next negedge
   task automatic step();
      @(negedge clk);
      sleep_req = '0; wake_req = '0; fvld = 1'b0; cop_on = '0; cop_off = '0;
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready", ready, 4'hF);
      check("R1 gate", pgate, 0);
      check("R1 cop", cop_en, 0);
      check("R1 freq", freq, 0);

      // R8 / R10 vectors, all cores running
      for (int i = 0; i < 8; i++) begin
         fvld = 1'b1; fidx = VEC_REQ[i];
         step();
         check($sformatf("R8/R10 vec %0d freq", i), freq, VEC_EXP[i]);
      end

      // R2 sleep wins over simultaneous wake on core 1
      sleep_req = 4'b0010; wake_req = 4'b0010;
      step();
      check("R2 gate", pgate, 4'b0010);
      check("R2 ready", ready, 4'b1101);

      // R6 sleep to gated core, wake to running core
      sleep_req = 4'b0010; wake_req = 4'b0001;
      step();
      check("R6 gate", pgate, 4'b0010);
      check("R6 ready", ready, 4'b1101);

      // R3 latency 3 on core 1
      wake_lat = 6'd3; wake_req = 4'b0010;
      step();
      check("R3 gate off at wake", pgate[1], 0);
      check("R4 not ready while waking", ready[1], 0);
      repeat (3) @(negedge clk);
      check("R3 not ready at L edges", ready[1], 0);
      @(negedge clk);
      check("R3 ready at L+1 edges", ready[1], 1);

      // R3 latency zero on core 2
      sleep_req = 4'b0100; step();
      wake_lat = 6'd0; wake_req = 4'b0100; step();
      check("R3 zero-lat waking", ready[2], 0);
      @(negedge clk);
      check("R3 zero-lat ready", ready[2], 1);

      // R7 latency captured at wake
      sleep_req = 4'b1000; step();
      wake_lat = 6'd2; wake_req = 4'b1000; step();
      wake_lat = 6'd40;
      repeat (2) @(negedge clk);
      check("R7 not ready at 2", ready[3], 0);
      @(negedge clk);
      check("R7 ready at 3", ready[3], 1);

      // R9 / R10 frequency held during core 0 recovery (current level 4)
      sleep_req = 4'b0001; step();
      wake_lat = 6'd5; wake_req = 4'b0001; step();      // after P0
      fvld = 1'b1; fidx = 3'd3; step();                  // after P0+1
      fvld = 1'b1; fidx = 3'd1; step();                  // after P0+2
      check("R9 held freq", freq, 4);
      fvld = 1'b1; fidx = 3'd7; step();                  // after P0+3
      repeat (3) @(negedge clk);                         // after P0+6
      check("R3 core0 ready", ready[0], 1);
      check("R9 still old at exit edge", freq, 4);
      @(negedge clk);                                    // after P0+7
      check("R9/R10 pending applied", freq, 1);

      // R5 held sleep during recovery of core 2
      sleep_req = 4'b0100; step();
      wake_lat = 6'd3; wake_req = 4'b0100; step();
      sleep_req = 4'b0100; step();
      check("R5 waking gate", pgate[2], 0);
      check("R5 waking ready", ready[2], 0);
      repeat (2) @(negedge clk);
      check("R5 before end", ready[2], 0);
      @(negedge clk);
      check("R5 back to gate", pgate[2], 1);
      check("R5 never ready", ready[2], 0);

      // R11 coprocessor supplies
      cop_on = 4'b0101; step();
      check("R11 on", cop_en, 4'b0101);
      cop_on = 4'b1001; cop_off = 4'b0001; step();
      check("R11 off wins", cop_en, 4'b1100);
      sleep_req = 4'b1000; step();
      check("R11 sleep keeps cop", cop_en, 4'b1100);
      check("R11 core3 gated", pgate[3], 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule